// File: doc/BRIEF.md
# Serial Wiper Position Controller

This block is a two-wire serial slave that holds the position of a 128-step digital resistor. The position is a 7-bit code. A decoder turns it into 128 one-hot tap-select lines, one per switch in the resistor string. When the block comes out of reset, the position is taken from a preset input rather than cleared. The preset input stands in for a value held in nonvolatile storage elsewhere.

A bus master can change the position in two ways. It can write an absolute value, or it can enter a step mode in which every following clock pulse moves the wiper one place. The direction of each move follows the data line. The master can also read the position back.

SCL and SDA are brought into the system clock domain through two-flop synchronisers. All protocol decisions are made on the synchronised edges. SDA is open-drain and is modelled as separate in, out and enable lines.

Top module: `wiper_i2c_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, `wiper_o` equals `preset_i`. The position is never cleared to zero by reset.
- R2: `tap_sel_o` always has exactly one bit set, at the index equal to `wiper_o`.
- R3: A write sequence stores bits 6..0 of the data byte and ignores bit 7. The sequence is START, device byte with bit 0 = 0, register byte 0x00, data byte, STOP. The device byte carries the device address in bits 7..1.
- R4: A read sequence returns a byte with bit 7 = 0 and the position in bits 6..0, sent most significant bit first. The sequence is START, device byte (write), register byte 0x00, repeated START, device byte with bit 0 = 1.
- R5: The slave acknowledges each byte of a valid write, read or step sequence by pulling SDA low during the ninth clock. It does not acknowledge the data byte that it returns on a read.
- R6: After the register byte 0x02 is acknowledged, step mode is active. Each SCL pulse samples SDA on its rising edge. A sampled 1 raises the position by one and a sampled 0 lowers it by one. The change is applied on that pulse's falling edge.
- R7: In step mode the position saturates at 127 going up and at 0 going down. It never wraps.
- R8: A STOP ends step mode. The position keeps its last value, and the slave stops driving SDA in the cycle after the STOP is seen.
- R9: A device byte whose address differs from the configured address (default 0x2C) is not acknowledged. The bytes that follow it, up to the next START, have no effect.
- R10: A register byte other than 0x00 or 0x02 is not acknowledged, and a data byte that follows it is not stored.
- R11: A START or STOP in the middle of a byte aborts the transfer, and the position does not change. With no write or step, the position holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_o | output | 1 | Value driven on SDA when enabled (always 0, open drain) |
| sda_oe | output | 1 | SDA pull-down enable |
| preset_i | input | 7 | Position loaded at reset |
| wiper_o | output | 7 | Current wiper position |
| tap_sel_o | output | 128 | One-hot tap switch select |

## Verification
The hardest case to reach is a STOP that closes step mode. The STOP itself needs a rising SCL edge while SDA is low, and that edge looks exactly like a "step down" pulse. The bench runs step sequences that begin at each end of the range and in mid-range. It then checks that the final position equals the pulse count applied with saturation, and nothing more. That shows the edge inside the STOP is never committed as a step. It also breaks a write with a STOP in the middle of the data byte, and it sends bytes with a wrong address and a wrong register.

// File: rtl/wiper_pkg.sv
package wiper_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_REG,
    ST_WDATA,
    ST_STEP,
    ST_RDATA,
    ST_WAIT
  } wstate_t;

  localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/wiper_bus_sync.sv
module wiper_bus_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [1:0] scl_ff;
  logic [1:0] sda_ff;
  logic       scl_d;
  logic       sda_d;
  logic       scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= 2'b11;
      sda_ff <= 2'b11;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[0], scl_i};
      sda_ff <= {sda_ff[0], sda_i};
      scl_d  <= scl_ff[1];
      sda_d  <= sda_ff[1];
    end
  end

  assign scl_s     = scl_ff[1];
  assign sda_s     = sda_ff[1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/wiper_proto.sv
module wiper_proto
  import wiper_pkg::*;
#(
  parameter int unsigned W          = 7,
  parameter logic [6:0]  DEV_ADDR   = 7'h2C,
  parameter logic [7:0]  POS_REG    = 8'h00,
  parameter logic [7:0]  STEP_REG   = 8'h02
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sda_s,
  input  logic         scl_rise,
  input  logic         scl_fall,
  input  logic         start_det,
  input  logic         stop_det,
  input  logic [W-1:0] wiper,
  output logic         wr_en,
  output logic [W-1:0] wr_data,
  output logic         inc,
  output logic         dec,
  output logic         sda_oe
);

  localparam int unsigned CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  wstate_t            state_q, state_d, after_q, after_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [BYTE_W-1:0]  sh_q, sh_d;
  logic               ack_q, ack_d;
  logic               arm_q, arm_d;
  logic               bit_q, bit_d;
  logic               bvld_q, bvld_d;

  always_comb begin
    state_d = state_q;
    after_d = after_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    ack_d   = ack_q;
    arm_d   = arm_q;
    bit_d   = bit_q;
    bvld_d  = bvld_q;
    wr_en   = 1'b0;
    inc     = 1'b0;
    dec     = 1'b0;
    if (stop_det) begin
      state_d = ST_IDLE;
      ack_d   = 1'b0;
      arm_d   = 1'b0;
      bvld_d  = 1'b0;
    end else if (start_det) begin
      state_d = ST_DEV;
      cnt_d   = '0;
      ack_d   = 1'b0;
      bvld_d  = 1'b0;
    end else begin
      unique case (state_q)
        ST_DEV, ST_REG, ST_WDATA: begin
          if (ack_q) begin
            if (scl_fall) begin
              ack_d   = 1'b0;
              cnt_d   = '0;
              state_d = after_q;
              if (after_q == ST_RDATA) sh_d = {1'b0, wiper};
            end
          end else if (scl_rise && cnt_q < FULL) begin
            sh_d  = {sh_q[BYTE_W-2:0], sda_s};
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == FULL) begin
            state_d = ST_WAIT;
            if (state_q == ST_DEV) begin
              if (sh_q[7:1] == DEV_ADDR && !sh_q[0]) begin
                ack_d = 1'b1; after_d = ST_REG;
              end else if (sh_q[7:1] == DEV_ADDR && arm_q) begin
                ack_d = 1'b1; after_d = ST_RDATA;
              end
            end else if (state_q == ST_REG) begin
              if (sh_q == POS_REG) begin
                ack_d = 1'b1; after_d = ST_WDATA; arm_d = 1'b1;
              end else if (sh_q == STEP_REG) begin
                ack_d = 1'b1; after_d = ST_STEP;
              end
            end else begin
              ack_d   = 1'b1;
              after_d = ST_WAIT;
              wr_en   = 1'b1;
            end
            if (ack_d) state_d = state_q;
          end
        end
        ST_STEP: begin
          if (scl_rise) begin
            bit_d  = sda_s;
            bvld_d = 1'b1;
          end else if (scl_fall && bvld_q) begin
            inc    = bit_q;
            dec    = ~bit_q;
            bvld_d = 1'b0;
          end
        end
        ST_RDATA: begin
          if (scl_fall) begin
            if (cnt_q == LAST) begin
              state_d = ST_WAIT;
            end else begin
              sh_d  = {sh_q[BYTE_W-2:0], 1'b0};
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      after_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      ack_q   <= 1'b0;
      arm_q   <= 1'b0;
      bit_q   <= 1'b0;
      bvld_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      after_q <= after_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      ack_q   <= ack_d;
      arm_q   <= arm_d;
      bit_q   <= bit_d;
      bvld_q  <= bvld_d;
    end
  end

  assign wr_data = sh_q[W-1:0];
  assign sda_oe  = ack_q | (state_q == ST_RDATA && !sh_q[BYTE_W-1]);

endmodule

// File: rtl/wiper_reg.sv
module wiper_reg #(
  parameter int unsigned W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] preset,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         inc,
  input  logic         dec,
  output logic         pend,
  output logic [W-1:0] wiper
);

  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic         pend_q;
  logic [W-1:0] pos_q, pos_d;
  logic         pos_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b1;
    else        pend_q <= 1'b0;
  end

  assign wiper  = pend_q ? preset : pos_q;
  assign pos_en = pend_q | wr_en | inc | dec;

  always_comb begin
    pos_d = wiper;
    if (pend_q)                      pos_d = preset;
    else if (wr_en)                  pos_d = wr_data;
    else if (inc && wiper != TOP)    pos_d = wiper + 1'b1;
    else if (dec && wiper != '0)     pos_d = wiper - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (pos_en) pos_q <= pos_d;
  end

  assign pend = pend_q;

endmodule

// File: rtl/wiper_tap_dec.sv
module wiper_tap_dec #(
  parameter int unsigned W = 7
) (
  input  logic [W-1:0]      code,
  output logic [(1<<W)-1:0] tap
);

  localparam int unsigned TAPS = 1 << W;

  for (genvar i = 0; i < TAPS; i++) begin : g_tap
    assign tap[i] = (code == W'(i));
  end

endmodule

// File: rtl/wiper_i2c_ctrl.sv
module wiper_i2c_ctrl #(
  parameter int unsigned W        = 7,
  parameter logic [6:0]  DEV_ADDR = 7'h2C,
  parameter logic [7:0]  POS_REG  = 8'h00,
  parameter logic [7:0]  STEP_REG = 8'h02
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_o,
  output logic              sda_oe,
  input  logic [W-1:0]      preset_i,
  output logic [W-1:0]      wiper_o,
  output logic [(1<<W)-1:0] tap_sel_o
);

  logic         sda_s, scl_rise, scl_fall, start_w, stop_w;
  logic         wr_w, inc_w, dec_w, pend_w;
  logic [W-1:0] wdata_w;

  wiper_bus_sync u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_w), .stop_det(stop_w)
  );

  wiper_proto #(.W(W), .DEV_ADDR(DEV_ADDR), .POS_REG(POS_REG), .STEP_REG(STEP_REG)) u_proto (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_w), .stop_det(stop_w),
    .wiper(wiper_o), .wr_en(wr_w), .wr_data(wdata_w), .inc(inc_w),
    .dec(dec_w), .sda_oe(sda_oe)
  );

  wiper_reg #(.W(W)) u_reg (
    .clk(clk), .rst_n(rst_n), .preset(preset_i), .wr_en(wr_w),
    .wr_data(wdata_w), .inc(inc_w), .dec(dec_w), .pend(pend_w),
    .wiper(wiper_o)
  );

  wiper_tap_dec #(.W(W)) u_dec (
    .code(wiper_o), .tap(tap_sel_o)
  );

  assign sda_o = 1'b0;

endmodule

// File: rtl/wiper_chk.sv
module wiper_chk #(
  parameter int unsigned W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic [W-1:0]      wiper,
  input logic [(1<<W)-1:0] tap,
  input logic              sda_oe,
  input logic              inc,
  input logic              dec,
  input logic              wr,
  input logic              pend,
  input logic              stop
);

  localparam logic [W-1:0] TOP = {W{1'b1}};

  // R2
  tap_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(tap) == 1) && tap[wiper]);

  // R7
  top_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !pend && wiper == TOP) |=> (wiper == TOP));

  // R7
  bottom_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !pend && wiper == '0) |=> (wiper == '0));

  // R6
  step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !pend && wiper != TOP) |=> (W'(wiper - $past(wiper)) == W'(1)));

  // R6
  step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !pend && wiper != '0) |=> (W'($past(wiper) - wiper) == W'(1)));

  // R8
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !sda_oe);

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(inc || dec || wr || pend) |=> $stable(wiper));

endmodule

bind wiper_i2c_ctrl wiper_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wiper(wiper_o), .tap(tap_sel_o),
  .sda_oe(sda_oe), .inc(inc_w), .dec(dec_w), .wr(wr_w),
  .pend(pend_w), .stop(stop_w)
);

// File: tb/wiper_i2c_ctrl_tb.sv
module wiper_i2c_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int Q          = 5;
  localparam int WD_CYCLES  = 150000;
  localparam logic [6:0] DEV = 7'h2C;
  localparam int NV = 13;
  // {op[1:0], arg[7:0], count[7:0], expected[6:0]}; op 0 write, 1 read, 2 step (arg[0]=up)
  localparam logic [24:0] VEC [NV] = '{
    {2'd0, 8'hA5, 8'd0, 7'h25},
    {2'd1, 8'h00, 8'd0, 7'h25},
    {2'd0, 8'h7F, 8'd0, 7'h7F},
    {2'd2, 8'h01, 8'd3, 7'h7F},
    {2'd1, 8'h00, 8'd0, 7'h7F},
    {2'd2, 8'h00, 8'd5, 7'h7A},
    {2'd1, 8'h00, 8'd0, 7'h7A},
    {2'd0, 8'h81, 8'd0, 7'h01},
    {2'd2, 8'h00, 8'd4, 7'h00},
    {2'd2, 8'h01, 8'd2, 7'h02},
    {2'd1, 8'h00, 8'd0, 7'h02},
    {2'd0, 8'h00, 8'd0, 7'h00},
    {2'd1, 8'h00, 8'd0, 7'h00}
  };

  logic         clk, rst_n, scl_m, sda_m;
  logic         sda_o, sda_oe;
  logic [6:0]   preset, wiper;
  logic [127:0] tap;
  wire          sda_line = sda_oe ? sda_o : sda_m;
  int           n_chk, n_bad;
  logic         done;

  wiper_i2c_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_o(sda_o), .sda_oe(sda_oe), .preset_i(preset),
    .wiper_o(wiper), .tap_sel_o(tap)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; tick(Q); scl_m = 1'b1; tick(Q); tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    ack = ~sda_line; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); scl_m = 1'b1; tick(Q); b[i] = sda_line; tick(Q); scl_m = 1'b0;
    end
    tick(Q);
    send_bit(1'b1);
  endtask

  task automatic do_write(input logic [7:0] d, output logic ok);
    logic a0, a1, a2;
    bus_start(); send_byte({DEV, 1'b0}, a0); send_byte(8'h00, a1);
    send_byte(d, a2); bus_stop();
    ok = a0 & a1 & a2;
  endtask

  task automatic do_read(output logic [7:0] d, output logic ok);
    logic a0, a1, a2;
    bus_start(); send_byte({DEV, 1'b0}, a0); send_byte(8'h00, a1);
    bus_start(); send_byte({DEV, 1'b1}, a2); recv_byte(d); bus_stop();
    ok = a0 & a1 & a2;
  endtask

  task automatic do_step(input logic up, input int n, output logic ok);
    logic a0, a1;
    bus_start(); send_byte({DEV, 1'b0}, a0); send_byte(8'h02, a1);
    for (int i = 0; i < n; i++) send_bit(up);
    bus_stop();
    ok = a0 & a1;
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic       ok, a;
    logic [7:0] rd;
    n_chk = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; preset = 7'h40;
    tick(4);
    chk("R1 preset during reset", wiper, 7'h40);
    rst_n = 1'b1; tick(4);
    chk("R1 preset after reset", wiper, 7'h40);
    chk("R2 tap at preset", int'(tap[64]), 1);
    chk("R8 idle no drive", int'(sda_oe), 0);

    for (int v = 0; v < NV; v++) begin
      case (VEC[v][24:23])
        2'd0: begin
          do_write(VEC[v][22:15], ok);
          chk("R5 write acks", int'(ok), 1);
        end
        2'd1: begin
          do_read(rd, ok);
          chk("R5 read acks", int'(ok), 1);
          chk("R4 read byte", rd, {1'b0, VEC[v][6:0]});
        end
        default: begin
          do_step(VEC[v][15], int'(VEC[v][14:7]), ok);
          chk("R5 step acks", int'(ok), 1);
          chk("R8 released after stop", int'(sda_oe), 0);
        end
      endcase
      tick(4);
      chk("R3 R6 R7 position", wiper, VEC[v][6:0]);
      chk("R2 tap line", int'(tap[VEC[v][6:0]]), 1);
    end

    // R7: long run up from 0 saturates at 127
    do_step(1'b1, 130, ok);
    tick(4);
    chk("R7 saturate top", wiper, 7'h7F);
    tick(40);
    chk("R8 hold after stop", wiper, 7'h7F);

    // R9: wrong device address
    bus_start(); send_byte({7'h2D, 1'b0}, a);
    chk("R9 no ack wrong addr", int'(a), 0);
    send_byte(8'h00, a); send_byte(8'h11, a); bus_stop(); tick(4);
    chk("R9 ignored bytes", wiper, 7'h7F);

    // R10: unknown register byte
    bus_start(); send_byte({DEV, 1'b0}, a); send_byte(8'h05, a);
    chk("R10 no ack bad reg", int'(a), 0);
    send_byte(8'h33, a); bus_stop(); tick(4);
    chk("R10 data not stored", wiper, 7'h7F);

    // R11: STOP in the middle of the data byte
    bus_start(); send_byte({DEV, 1'b0}, a); send_byte(8'h00, a);
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    bus_stop(); tick(4);
    chk("R11 aborted write", wiper, 7'h7F);

    // R1: second reset with another preset
    preset = 7'h15; rst_n = 1'b0; tick(3);
    chk("R1 reset reload", wiper, 7'h15);
    rst_n = 1'b1; tick(6);
    chk("R1 after second reset", wiper, 7'h15);
    chk("R2 tap after reset", int'(tap[21]), 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule